// File: doc/BRIEF.md
# Two-level priority interrupt controller

This block sits next to a processor core and turns 32 level-sensitive request lines into interrupt deliveries at two priority levels. Software masks or unmasks each line through an enable register and places each line at low priority (level 1) or high priority (level 2) through a level register. A status word holds a global enable and an active flag for each level. When a request can be delivered, the controller raises a one-cycle take strobe with the level and the number of the winning line, and it marks that level active.

Each level has a single saved context. A level-2 request may therefore interrupt a running level-1 handler, but a level-1 request is held back while any handler is active. The core ends a handler with a return pulse for its level. A level-2 return puts the level-1 active flag back to the value it had when the level-2 handler was entered. Line 3 carries the timer. Lines 0 to 2 are reserved and can never be unmasked.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A line whose enable bit is 0 never causes a take, whatever its input does.
- R2: Enable bits 0, 1 and 2 always read as 0. Writes to them are dropped.
- R3: In the level register, a 1 in bit n places line n at level 2 and a 0 places it at level 1. `irq_level` reports the level of each take (1 means level 2).
- R4: Requests are level-sensitive. A line that goes high and then low while it cannot be delivered leaves nothing pending behind it.
- R5: After reset, the enable, level and status registers all read as 0, and no take occurs.
- R6: Among the deliverable lines of the chosen level, the lowest-numbered line wins. Its number appears on `irq_cause` together with a one-cycle `irq_take`, on the clock edge after the request is seen.
- R7: A level-1 take happens only when E1 is 1, A1 is 0 and A2 is 0.
- R8: A level-2 take happens when E2 is 1 and A2 is 0, including while A1 is 1. If both levels could be taken in the same cycle, level 2 wins.
- R9: A take sets the active flag of its level. While that flag stays set, no further take of the same level occurs.
- R10: A `ret_l2` pulse while A2 is 1 clears A2 and restores A1 to its value at the level-2 take. A `ret_l1` pulse clears A1 only when A2 is 0, and has no effect while A2 is 1.
- R11: The register port maps address 0 to enable, 1 to level and 2 to status, with bit0=A1, bit1=A2, bit2=E1 and bit3=E2. A write takes effect on the next edge. Read data is registered one cycle after `reg_re`. A status write changes only E1 and E2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive request lines |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ret_l1 | input | 1 | Level-1 return pulse |
| ret_l2 | input | 1 | Level-2 return pulse |
| irq_take | output | 1 | One-cycle delivery strobe |
| irq_level | output | 1 | Level of the delivery (1 = level 2) |
| irq_cause | output | 5 | Number of the delivered line |

## Verification
The bench holds pairs of level-1 lines high together, which shows whether the lowest-numbered line wins. It keeps those lines high after the take, which shows whether re-entry is blocked. It raises a level-2 line on top of an active level-1 handler, which separates legal preemption from illegal level-1 delivery under level 2. It sends return pulses in both nestings, which shows whether the restore brings back a saved A1 of 1 and also one of 0. Masked lines, a pulse that is dropped before enabling, and cleared E1 or E2 bits must all produce no take.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NLINES = 32,
  parameter int NRSV   = 3,
  parameter int CW     = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [1:0]        reg_addr,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [NLINES-1:0] reg_rdata,
  input  logic              ret_l1,
  input  logic              ret_l2,
  output logic              irq_take,
  output logic              irq_level,
  output logic [CW-1:0]     irq_cause
);
  localparam logic [NLINES-1:0] WR_MASK = {{(NLINES-NRSV){1'b1}}, {NRSV{1'b0}}};

  logic [NLINES-1:0] en_q, lvl_q;
  logic a1_q, a2_q, e1_q, e2_q, sav_a1;

  function automatic logic [CW-1:0] lowest(input logic [NLINES-1:0] v);
    lowest = '0;
    for (int i = NLINES-1; i >= 0; i--)
      if (v[i]) lowest = CW'(i);
  endfunction

  wire [NLINES-1:0] pend = irq_lines & en_q;
  wire [NLINES-1:0] p2   = pend & lvl_q;
  wire [NLINES-1:0] p1   = pend & ~lvl_q;
  wire go2     = e2_q & ~a2_q & (|p2);
  wire go1     = e1_q & ~a1_q & ~a2_q & (|p1) & ~go2;
  wire ret1_ok = ret_l1 & a1_q & ~a2_q;
  wire ret2_ok = ret_l2 & a2_q;
  wire a1_base = ret2_ok ? sav_a1 : (ret1_ok ? 1'b0 : a1_q);
  wire [NLINES-1:0] status = {{(NLINES-4){1'b0}}, e2_q, e1_q, a2_q, a1_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1_q   <= 1'b0;
      a2_q   <= 1'b0;
      sav_a1 <= 1'b0;
    end else begin
      a1_q <= go1 | a1_base;
      a2_q <= go2 | (a2_q & ~ret2_ok);
      if (go2) sav_a1 <= a1_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_take  <= 1'b0;
      irq_level <= 1'b0;
      irq_cause <= '0;
    end else begin
      irq_take <= go1 | go2;
      if (go2) begin
        irq_level <= 1'b1;
        irq_cause <= lowest(p2);
      end else if (go1) begin
        irq_level <= 1'b0;
        irq_cause <= lowest(p1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
      e1_q  <= 1'b0;
      e2_q  <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: en_q <= reg_wdata & WR_MASK;
        2'd1: lvl_q <= reg_wdata;
        2'd2: begin
          e1_q <= reg_wdata[2];
          e2_q <= reg_wdata[3];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_re) begin
      case (reg_addr)
        2'd0:    reg_rdata <= en_q;
        2'd1:    reg_rdata <= lvl_q;
        2'd2:    reg_rdata <= status;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] irq_lines,
  input logic [31:0] en_q,
  input logic [31:0] lvl_q,
  input logic        a1_q,
  input logic        a2_q,
  input logic        ret_l2,
  input logic        irq_take,
  input logic        irq_level,
  input logic [4:0]  irq_cause
);
  AST_RSV_MASKED: assert property (@(posedge clk) disable iff (!rst_n) en_q[2:0] == 3'b000); // R2
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ((($past(irq_lines & en_q)) >> irq_cause) & 32'd1) == 32'd1); // R1
  AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ((($past(lvl_q)) >> irq_cause) & 32'd1) == {31'd0, irq_level}); // R3
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (($past(irq_lines & en_q) & (irq_level ? $past(lvl_q) : ~$past(lvl_q))
                   & ((32'd1 << irq_cause) - 32'd1)) == 32'd0)); // R6
  AST_NO_L1_UNDER_L2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !irq_level) |-> !$past(a2_q)); // R7
  AST_NO_L1_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !irq_level) |-> !$past(a1_q)); // R9
  AST_TAKE_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_level ? a2_q : a1_q)); // R9
  AST_RET2_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_l2 && a2_q) |=> !a2_q); // R10
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .en_q(en_q), .lvl_q(lvl_q),
  .a1_q(a1_q), .a2_q(a2_q), .ret_l2(ret_l2),
  .irq_take(irq_take), .irq_level(irq_level), .irq_cause(irq_cause)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [31:0] irq_lines = '0, reg_wdata = '0, reg_rdata;
  logic reg_we = 0, reg_re = 0, ret_l1 = 0, ret_l2 = 0;
  logic [1:0] reg_addr = '0;
  logic irq_take, irq_level;
  logic [4:0] irq_cause;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [5:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ret_l1(ret_l1), .ret_l2(ret_l2), .irq_take(irq_take), .irq_level(irq_level),
    .irq_cause(irq_cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_take(input logic lvl, input int cause, input string req);
    exp_q.push_back({lvl, 5'(cause)});
    tag_q.push_back(req);
  endtask

  always @(negedge clk) if (rst_n && irq_take && !done) begin
    if (exp_q.size() == 0) chk("R1/R7/R9 unexpected take", {26'd0, irq_level, irq_cause}, 32'hFFFF_FFFF);
    else begin
      string t = tag_q.pop_front();
      chk(t, {26'd0, irq_level, irq_cause}, {26'd0, exp_q.pop_front()});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1 reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1 reg_re = 1; reg_addr = a;
    @(posedge clk); #1 reg_re = 0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic lines(input logic [31:0] v);
    @(posedge clk); #1 irq_lines = v;
  endtask

  task automatic pulse_ret(input bit lvl2);
    @(posedge clk); #1 if (lvl2) ret_l2 = 1; else ret_l1 = 1;
    @(posedge clk); #1 ret_l1 = 0; ret_l2 = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); chk("R5 take idle", {31'd0, irq_take}, 0);
    rd(0, 0, "R5 enable reset");
    rd(1, 0, "R5 level reset");
    rd(2, 0, "R5 status reset");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'hFFFF_FFF8, "R2 reserved bits read 0");
    wr(0, 0);
    wr(2, 32'h4);
    lines(32'h40); idle(5);            // R1: line 6 masked, no take
    lines(0);
    rd(2, 32'h4, "R1 masked line left A1 clear");
    wr(0, 32'h40); idle(5);            // R4: nothing latched
    rd(2, 32'h4, "R4 dropped pulse not latched");
    wr(0, (1<<3)|(1<<5)|(1<<6)|(1<<9)|(1<<12));
    expect_take(0, 5, "R6 lowest L1 line wins");
    lines((1<<5)|(1<<9)); idle(3);
    rd(2, 32'h5, "R9 A1 set by take");
    idle(5);                           // R9: held lines, no re-entry
    wr(1, 1<<12);
    wr(2, 32'hC);
    rd(2, 32'hD, "R11 status write keeps A1");
    expect_take(1, 12, "R8 L2 preempts A1");
    lines((1<<5)|(1<<9)|(1<<12)); idle(3);
    rd(2, 32'hF, "R3 R8 A2 set with A1");
    pulse_ret(0);
    rd(2, 32'hF, "R10 ret_l1 ignored under A2");
    lines((1<<5)|(1<<9));
    pulse_ret(1);
    rd(2, 32'hD, "R10 ret_l2 restores A1=1");
    lines(1<<9);
    expect_take(0, 9, "R7 L1 after ret_l1");
    pulse_ret(0); idle(2);
    rd(2, 32'hD, "R9 A1 after second take");
    wr(2, 32'h8);
    lines(0);
    pulse_ret(0);
    rd(2, 32'h8, "R10 ret_l1 clears A1");
    lines(1<<9); idle(5);              // R7: E1=0 blocks
    wr(2, 32'h0);
    lines((1<<9)|(1<<12)); idle(5);    // R8: E2=0 blocks
    expect_take(1, 12, "R8 L2 with E2 set, A1 clear");
    wr(2, 32'h8); idle(3);
    rd(2, 32'hA, "R9 A2 set");
    lines(0);
    pulse_ret(1);
    rd(2, 32'h8, "R10 ret_l2 restores A1=0");
    wr(1, 32'h0000_00F0);
    rd(1, 32'h0000_00F0, "R11 level register readback");
    idle(2);
    chk("R6 all expected takes seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule